// File: doc/BRIEF.md
# Two-Level Branch Address Cache

This block turns one fetch address into the start addresses of the next two basic blocks in a single cycle. It is a direct-mapped table. Each entry describes the primary branch found at the fetch address and the secondary branch that follows on each of its two paths. The entry holds the taken and fall-through addresses at the first level and the four addresses reachable at the second level.

A lookup compares the stored tag with the fetch address. Two direction predictions, made elsewhere in the same cycle, then steer a select stage. The select stage returns two fetch addresses, each with a valid flag. When the first flag is low, the fetch unit continues at the sequential address.

A single write port fills or updates a whole entry in one clock. The lookup path is combinational from the fetch address and the predictions, so results appear in the same cycle as the request.

Top module: `bac_dual_lookup`

## Requirements
- R1: A lookup hits when the entry at index `fetchAddr[6:2]` holds a tag equal to `fetchAddr[31:7]` and its primary branch is marked valid. On a hit, `nextVld1` is 1.
- R2: On a hit, `nextAddr1` is the stored first-level taken address if the primary branch resolves taken, and the stored first-level fall-through address otherwise.
- R3: `wrAddrL2` packs four second-level addresses, slot k at bits `[k*32 +: 32]`. Slot 3 is taken/taken, slot 2 is taken/not-taken, slot 1 is not-taken/taken and slot 0 is not-taken/not-taken. `nextAddr2` is the slot indexed by {primary resolved taken, secondary resolved taken}.
- R4: On a tag mismatch, or when the entry's primary valid bit is 0, both `nextVld1` and `nextVld2` are 0.
- R5: `nextVld2` is 1 only when `nextVld1` is 1 and the secondary branch on the chosen path is marked valid in the entry.
- R6: Branch type codes are 0 conditional, 1 unconditional, 2 return and 3 other. An unconditional type at a level resolves that level taken regardless of its prediction. Every other type follows the prediction input.
- R7: An output whose valid flag is 0 drives address 0.
- R8: A write is taken at the rising clock edge and is visible to lookups from the next cycle. A lookup in the same cycle as the write sees the old contents.
- R9: After reset, every entry is invalid, so every lookup misses.
- R10: A write changes only the entry at its own index. A write with a new tag at an index replaces the old entry, and the old tag then misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset, clears entry valid bits |
| fetchAddr | input | 32 | Lookup address |
| predPrim | input | 1 | Predicted direction of the primary branch (1 = taken) |
| predSec | input | 1 | Predicted direction of the secondary branch (1 = taken) |
| wrEn | input | 1 | Write strobe for a whole entry |
| wrAddr | input | 32 | Fetch address that the written entry belongs to (gives index and tag) |
| wrPrimVld | input | 1 | Primary branch valid |
| wrPrimType | input | 2 | Primary branch type |
| wrAddrT | input | 32 | First-level taken address |
| wrAddrN | input | 32 | First-level fall-through address |
| wrSecTVld | input | 1 | Secondary branch on the taken path valid |
| wrSecTType | input | 2 | Type of the secondary branch on the taken path |
| wrSecNVld | input | 1 | Secondary branch on the fall-through path valid |
| wrSecNType | input | 2 | Type of the secondary branch on the fall-through path |
| wrAddrL2 | input | 128 | Four second-level addresses, slots as in R3 |
| nextAddr1 | output | 32 | First next-block address |
| nextVld1 | output | 1 | First address valid |
| nextAddr2 | output | 32 | Second next-block address |
| nextVld2 | output | 1 | Second address valid |

## Verification
The lookup outputs are combinational in the fetch address and the two predictions, so they are due in the same cycle as the request. The bench drives inputs on the falling edge and samples one nanosecond later, before the next rising edge. A write takes effect on the first rising edge after it is driven. The bench therefore checks a lookup of the written index once just before that edge, expecting the old contents, and once just after it, expecting the new contents.

// File: rtl/bac_pkg.sv
package bac_pkg;

  typedef enum logic [1:0] {
    BR_COND   = 2'd0,
    BR_UNCOND = 2'd1,
    BR_RET    = 2'd2,
    BR_OTHER  = 2'd3
  } brType_e;

  // status of the addressed entry, datapath -> control
  typedef struct packed {
    logic    hit;
    logic    primVld;
    brType_e primType;
    logic    secTVld;
    brType_e secTType;
    logic    secNVld;
    brType_e secNType;
  } entryStat_t;

  // select strobes, control -> datapath
  typedef struct packed {
    logic selTaken1;
    logic selTaken2;
    logic out1Vld;
    logic out2Vld;
  } selStrobe_t;

endpackage

// File: rtl/bac_ctrl.sv
module bac_ctrl
  import bac_pkg::*;
(
  input  entryStat_t stat,
  input  logic       predPrim,
  input  logic       predSec,
  output selStrobe_t strobe
);

  logic    takenPrim;
  logic    takenSec;
  logic    pathSecVld;
  brType_e pathSecType;

  always_comb begin
    takenPrim   = predPrim || (stat.primType == BR_UNCOND);
    pathSecVld  = takenPrim ? stat.secTVld  : stat.secNVld;
    pathSecType = takenPrim ? stat.secTType : stat.secNType;
    takenSec    = predSec || (pathSecType == BR_UNCOND);

    strobe.out1Vld   = stat.hit && stat.primVld;
    strobe.out2Vld   = strobe.out1Vld && pathSecVld;
    strobe.selTaken1 = takenPrim;
    strobe.selTaken2 = takenSec;
  end

endmodule

// File: rtl/bac_dpath.sv
module bac_dpath
  import bac_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 5,
  parameter int OFS_W  = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   fetchAddr,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic                wrPrimVld,
  input  logic [1:0]          wrPrimType,
  input  logic [ADDR_W-1:0]   wrAddrT,
  input  logic [ADDR_W-1:0]   wrAddrN,
  input  logic                wrSecTVld,
  input  logic [1:0]          wrSecTType,
  input  logic                wrSecNVld,
  input  logic [1:0]          wrSecNType,
  input  logic [4*ADDR_W-1:0] wrAddrL2,
  input  selStrobe_t          strobe,
  output entryStat_t          stat,
  output logic [ADDR_W-1:0]   nextAddr1,
  output logic [ADDR_W-1:0]   nextAddr2
);

  localparam int ENTRIES = 1 << IDX_W;
  localparam int TAG_LO  = IDX_W + OFS_W;
  localparam int TAG_W   = ADDR_W - TAG_LO;
  localparam int L2_SLOTS = 4;

  logic [TAG_W-1:0]  tagMem   [ENTRIES];
  logic              primVldMem [ENTRIES];
  logic [1:0]        primTypeMem[ENTRIES];
  logic              secTVldMem [ENTRIES];
  logic [1:0]        secTTypeMem[ENTRIES];
  logic              secNVldMem [ENTRIES];
  logic [1:0]        secNTypeMem[ENTRIES];
  logic [ADDR_W-1:0] addrTMem  [ENTRIES];
  logic [ADDR_W-1:0] addrNMem  [ENTRIES];
  logic [ADDR_W-1:0] addrL2Mem [L2_SLOTS][ENTRIES];

  logic [IDX_W-1:0] rdIdx, wrIdx;
  logic [TAG_W-1:0] rdTag, wrTag;
  logic [OFS_W-1:0] unusedOfs;

  assign rdIdx     = fetchAddr[TAG_LO-1:OFS_W];
  assign rdTag     = fetchAddr[ADDR_W-1:TAG_LO];
  assign wrIdx     = wrAddr[TAG_LO-1:OFS_W];
  assign wrTag     = wrAddr[ADDR_W-1:TAG_LO];
  assign unusedOfs = fetchAddr[OFS_W-1:0] ^ wrAddr[OFS_W-1:0];

  // valid bits: cleared by reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int e = 0; e < ENTRIES; e++) begin
        primVldMem[e] <= 1'b0;
        secTVldMem[e] <= 1'b0;
        secNVldMem[e] <= 1'b0;
      end
    end else if (wrEn) begin
      primVldMem[wrIdx] <= wrPrimVld;
      secTVldMem[wrIdx] <= wrSecTVld;
      secNVldMem[wrIdx] <= wrSecNVld;
    end
  end

  // payload: no reset needed, gated by valid bits
  always_ff @(posedge clk) begin
    if (wrEn) begin
      tagMem[wrIdx]      <= wrTag;
      primTypeMem[wrIdx] <= wrPrimType;
      secTTypeMem[wrIdx] <= wrSecTType;
      secNTypeMem[wrIdx] <= wrSecNType;
      addrTMem[wrIdx]    <= wrAddrT;
      addrNMem[wrIdx]    <= wrAddrN;
    end
  end

  for (genvar s = 0; s < L2_SLOTS; s++) begin : g_l2
    always_ff @(posedge clk) begin
      if (wrEn) addrL2Mem[s][wrIdx] <= wrAddrL2[s*ADDR_W +: ADDR_W];
    end
  end

  always_comb begin
    stat.hit      = (tagMem[rdIdx] == rdTag);
    stat.primVld  = primVldMem[rdIdx];
    stat.primType = brType_e'(primTypeMem[rdIdx]);
    stat.secTVld  = secTVldMem[rdIdx];
    stat.secTType = brType_e'(secTTypeMem[rdIdx]);
    stat.secNVld  = secNVldMem[rdIdx];
    stat.secNType = brType_e'(secNTypeMem[rdIdx]);
  end

  logic [1:0] l2Slot;
  assign l2Slot = {strobe.selTaken1, strobe.selTaken2};

  always_comb begin
    nextAddr1 = '0;
    nextAddr2 = '0;
    if (strobe.out1Vld)
      nextAddr1 = strobe.selTaken1 ? addrTMem[rdIdx] : addrNMem[rdIdx];
    if (strobe.out2Vld)
      nextAddr2 = addrL2Mem[l2Slot][rdIdx];
  end

  // R8: the written tag is in place from the next cycle
  p_write_lands_r8: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> (tagMem[$past(wrIdx)] == $past(wrTag)));

  // R9, R10: a written primary valid bit is held
  p_valid_lands_r10: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> (primVldMem[$past(wrIdx)] == $past(wrPrimVld)));

endmodule

// File: rtl/bac_dual_lookup.sv
module bac_dual_lookup
  import bac_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 5,
  parameter int OFS_W  = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   fetchAddr,
  input  logic                predPrim,
  input  logic                predSec,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic                wrPrimVld,
  input  logic [1:0]          wrPrimType,
  input  logic [ADDR_W-1:0]   wrAddrT,
  input  logic [ADDR_W-1:0]   wrAddrN,
  input  logic                wrSecTVld,
  input  logic [1:0]          wrSecTType,
  input  logic                wrSecNVld,
  input  logic [1:0]          wrSecNType,
  input  logic [4*ADDR_W-1:0] wrAddrL2,
  output logic [ADDR_W-1:0]   nextAddr1,
  output logic                nextVld1,
  output logic [ADDR_W-1:0]   nextAddr2,
  output logic                nextVld2
);

  entryStat_t stat;
  selStrobe_t strobe;

  bac_dpath #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFS_W(OFS_W)) u_dpath (
    .clk, .rstN, .fetchAddr, .wrEn, .wrAddr, .wrPrimVld, .wrPrimType,
    .wrAddrT, .wrAddrN, .wrSecTVld, .wrSecTType, .wrSecNVld, .wrSecNType,
    .wrAddrL2, .strobe, .stat, .nextAddr1, .nextAddr2
  );

  bac_ctrl u_ctrl (
    .stat, .predPrim, .predSec, .strobe
  );

  assign nextVld1 = strobe.out1Vld;
  assign nextVld2 = strobe.out2Vld;

  p_miss_invalid_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!stat.hit || !stat.primVld) |-> (!nextVld1 && !nextVld2));

  p_vld2_needs_vld1_r5: assert property (@(posedge clk) disable iff (!rstN)
    nextVld2 |-> nextVld1);

  p_zero_addr1_r7: assert property (@(posedge clk) disable iff (!rstN)
    !nextVld1 |-> (nextAddr1 == '0));

  p_zero_addr2_r7: assert property (@(posedge clk) disable iff (!rstN)
    !nextVld2 |-> (nextAddr2 == '0));

endmodule

// File: tb/sim_bac_dual_lookup.sv
module sim_bac_dual_lookup;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [31:0]  fetchAddr = '0;
  logic         predPrim = 1'b0, predSec = 1'b0;
  logic         wrEn = 1'b0;
  logic [31:0]  wrAddr = '0;
  logic         wrPrimVld = 1'b0;
  logic [1:0]   wrPrimType = '0;
  logic [31:0]  wrAddrT = '0, wrAddrN = '0;
  logic         wrSecTVld = 1'b0, wrSecNVld = 1'b0;
  logic [1:0]   wrSecTType = '0, wrSecNType = '0;
  logic [127:0] wrAddrL2 = '0;
  logic [31:0]  nextAddr1, nextAddr2;
  logic         nextVld1, nextVld2;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  bac_dual_lookup u0 (
    .clk, .rstN, .fetchAddr, .predPrim, .predSec, .wrEn, .wrAddr,
    .wrPrimVld, .wrPrimType, .wrAddrT, .wrAddrN, .wrSecTVld, .wrSecTType,
    .wrSecNVld, .wrSecNType, .wrAddrL2, .nextAddr1, .nextVld1,
    .nextAddr2, .nextVld2
  );

  function automatic logic [31:0] fa(input logic [24:0] tag, input logic [4:0] idx);
    return {tag, idx, 2'b00};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // entry with addresses derived from a seed
  task automatic driveEntry(input logic [31:0] a, input logic pv, input logic [1:0] pt,
                            input logic tv, input logic [1:0] tt,
                            input logic nv, input logic [1:0] nt, input logic [7:0] seed);
    wrAddr = a; wrPrimVld = pv; wrPrimType = pt;
    wrSecTVld = tv; wrSecTType = tt; wrSecNVld = nv; wrSecNType = nt;
    wrAddrT = {seed, 24'h00_1000};
    wrAddrN = {seed, 24'h00_2000};
    for (int s = 0; s < 4; s++) wrAddrL2[s*32 +: 32] = {seed, 16'h0030, 6'd0, 2'(s)};
    wrEn = 1'b1;
  endtask

  task automatic writeEntry(input logic [31:0] a, input logic pv, input logic [1:0] pt,
                            input logic tv, input logic [1:0] tt,
                            input logic nv, input logic [1:0] nt, input logic [7:0] seed);
    @(negedge clk);
    driveEntry(a, pv, pt, tv, tt, nv, nt, seed);
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic look(input logic [31:0] a, input logic p1, input logic p2);
    @(negedge clk);
    fetchAddr = a; predPrim = p1; predSec = p2;
    #1;
  endtask

  function automatic logic [31:0] l2Of(input logic [7:0] seed, input int s);
    return {seed, 16'h0030, 6'd0, 2'(s)};
  endfunction

  task automatic t_reset;
    for (int i = 0; i < 3; i++) begin
      look(fa(25'(i * 7), 5'(i * 11)), 1'b1, 1'b1);
      check("R9 vld1 after reset", 32'(nextVld1), 0);
      check("R9 vld2 after reset", 32'(nextVld2), 0);
      check("R7 addr1 zero", nextAddr1, 0);
    end
  endtask

  task automatic t_paths;
    logic [31:0] a;
    a = fa(25'h0ABCD, 5'd3);
    writeEntry(a, 1, 2'd0, 1, 2'd0, 1, 2'd0, 8'hA1);
    for (int p = 0; p < 4; p++) begin
      look(a, p[1], p[0]);
      check("R1 hit vld1", 32'(nextVld1), 1);
      check("R2 addr1", nextAddr1, p[1] ? 32'hA100_1000 : 32'hA100_2000);
      check("R3 vld2", 32'(nextVld2), 1);
      check("R3 addr2", nextAddr2, l2Of(8'hA1, p));
    end
  endtask

  task automatic t_types;
    logic [31:0] a;
    a = fa(25'h00777, 5'd9);
    // unconditional primary, unconditional secondary on taken path
    writeEntry(a, 1, 2'd1, 1, 2'd1, 1, 2'd0, 8'hB2);
    look(a, 1'b0, 1'b0);
    check("R6 uncond primary addr1", nextAddr1, 32'hB200_1000);
    check("R6 uncond secondary addr2", nextAddr2, l2Of(8'hB2, 3));
    // return and other follow predictions
    writeEntry(a, 1, 2'd2, 1, 2'd3, 1, 2'd3, 8'hB3);
    look(a, 1'b0, 1'b0);
    check("R6 return follows pred addr1", nextAddr1, 32'hB300_2000);
    check("R6 other follows pred addr2", nextAddr2, l2Of(8'hB3, 0));
    look(a, 1'b1, 1'b1);
    check("R6 other taken addr2", nextAddr2, l2Of(8'hB3, 3));
  endtask

  task automatic t_secValid;
    logic [31:0] a;
    a = fa(25'h01234, 5'd17);
    writeEntry(a, 1, 2'd0, 0, 2'd0, 1, 2'd0, 8'hC4);
    look(a, 1'b1, 1'b1);
    check("R5 vld1 with taken path", 32'(nextVld1), 1);
    check("R5 vld2 secondary invalid", 32'(nextVld2), 0);
    check("R7 addr2 zero", nextAddr2, 0);
    look(a, 1'b0, 1'b1);
    check("R5 vld2 fall-through path", 32'(nextVld2), 1);
    check("R3 addr2 NT slot", nextAddr2, l2Of(8'hC4, 1));
  endtask

  task automatic t_miss;
    logic [31:0] a;
    a = fa(25'h05555, 5'd21);
    writeEntry(a, 1, 2'd0, 1, 2'd0, 1, 2'd0, 8'hD5);
    look(fa(25'h05556, 5'd21), 1'b1, 1'b0);
    check("R4 tag miss vld1", 32'(nextVld1), 0);
    check("R4 tag miss vld2", 32'(nextVld2), 0);
    check("R7 miss addr1", nextAddr1, 0);
    writeEntry(a, 0, 2'd1, 1, 2'd0, 1, 2'd0, 8'hD6);
    look(a, 1'b1, 1'b0);
    check("R4 primary invalid vld1", 32'(nextVld1), 0);
    check("R4 primary invalid vld2", 32'(nextVld2), 0);
  endtask

  task automatic t_writeTiming;
    logic [31:0] a;
    a = fa(25'h0F0F0, 5'd30);
    writeEntry(a, 1, 2'd0, 1, 2'd0, 1, 2'd0, 8'hE1);
    @(negedge clk);
    fetchAddr = a; predPrim = 1'b1; predSec = 1'b0;
    driveEntry(a, 1, 2'd0, 1, 2'd0, 1, 2'd0, 8'hE2);
    #1;
    check("R8 same-cycle sees old", nextAddr1, 32'hE100_1000);
    @(posedge clk); #1;
    wrEn = 1'b0;
    check("R8 next cycle sees new", nextAddr1, 32'hE200_1000);
    check("R8 next cycle addr2", nextAddr2, l2Of(8'hE2, 2));
  endtask

  task automatic t_isolation;
    logic [31:0] a3, a4;
    a3 = fa(25'h0ABCD, 5'd3);
    a4 = fa(25'h0ABCD, 5'd4);
    writeEntry(a4, 1, 2'd0, 1, 2'd0, 1, 2'd0, 8'hF1);
    look(a3, 1'b1, 1'b1);
    check("R10 neighbour intact", nextAddr1, 32'hA100_1000);
    writeEntry(fa(25'h00042, 5'd3), 1, 2'd0, 1, 2'd0, 1, 2'd0, 8'hF2);
    look(a3, 1'b1, 1'b1);
    check("R10 old tag evicted", 32'(nextVld1), 0);
    look(fa(25'h00042, 5'd3), 1'b0, 1'b0);
    check("R10 new tag hits", nextAddr1, 32'hF200_2000);
    look(a4, 1'b0, 1'b1);
    check("R10 index 4 unchanged", nextAddr2, l2Of(8'hF1, 1));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    t_reset();
    t_paths();
    t_types();
    t_secValid();
    t_miss();
    t_writeTiming();
    t_isolation();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule